// File: doc/BRIEF.md
# Register-Mapped JTAG Shift Engine

This block lets host software run JTAG scans through a small 32-bit register window. Software writes how many bits to shift, then a TMS vector, then a TDI vector. The TDI write starts the operation. The engine produces that many TCK pulses and sends the vectors out least significant bit first. It samples TDO on every rising edge and collects those samples into a result word, which software reads back at the same offset it used for TDI. One operation covers at most 32 bits, so longer scans are issued as a series of chunks.

Two read-only words at the bottom of the window let software find and identify the block. The first is an extended-capability header, and the second is a vendor-specific header that carries an ID and the length of the structure. The TCK half period is programmable in system clocks. A busy flag, shown both as a port and as a status bit, stays high until the last falling edge of TCK.

Top module: `jsh_engine`

## Requirements
- R1: Offset 0x00 reads a capability header: bits [15:0] = 0x000B, [19:16] = version (default 1), [31:20] = next pointer (default 0), giving 0x0001000B.
- R2: Offset 0x04 reads a vendor header: bits [15:0] = ID 0x0008, [19:16] = revision (default 0), [31:20] = length 0x020, giving 0x02000008.
- R3: A write to offset 0x14 with length N (offset 0x0C, bits [5:0]) produces exactly N TCK pulses. TCK is low whenever the engine is idle.
- R4: Bit i of the TMS vector (offset 0x10) and bit i of the TDI write data are presented on the i-th TCK rising edge, LSB first. They change only while TCK is low.
- R5: The TDO value sampled on rising edge i lands in bit i of the word read at 0x14. Bits at or above N read zero.
- R6: TCK high and low phases each last H system clocks, where H is the value at offset 0x18 bits [7:0] (reset 1). A value of 0 acts as 1.
- R7: Busy (port and offset 0x08 bit 0) rises on the clock after the start write. It stays high for exactly 2·H·N clocks and falls together with the last TCK falling edge.
- R8: A length of 0 produces no TCK pulse, leaves busy low and sets the result to 0. Lengths from 33 to 63 behave as 32.
- R9: While busy, writes to offsets 0x0C, 0x10, 0x14 and 0x18 are ignored. This includes a second start.
- R10: All-zero TMS and TDI vectors still give N TCK pulses, so the engine can clock the TAP while it idles.
- R11: After reset, TCK, TMS, TDI and busy are low, the length and TMS registers read 0, and the result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to the chain |
| jtag_tdo | input | 1 | Test data from the chain |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check the following on every cycle:
- TCK stays low while idle.
- TMS and TDI hold steady while TCK is high.
- Busy falls only together with a TCK falling edge.
- A zero-length start never raises busy.
- Registers do not move under writes made while busy.

Only the directed scenarios can show the rest:
- Correct bit ordering and result placement.
- Exact pulse counts and busy duration.
- Half-period timing.
- Clamping of oversized lengths.
- The identification words.

// File: rtl/jsh_pkg.sv
package jsh_pkg;
   localparam int unsigned REG_W = 32;
   // byte offsets: host software decodes these, so they are fixed
   localparam logic [7:0] OFS_CAP   = 8'h00;
   localparam logic [7:0] OFS_VHDR  = 8'h04;
   localparam logic [7:0] OFS_STAT  = 8'h08;
   localparam logic [7:0] OFS_LEN   = 8'h0C;
   localparam logic [7:0] OFS_TMS   = 8'h10;
   localparam logic [7:0] OFS_DATA  = 8'h14;
   localparam logic [7:0] OFS_HALF  = 8'h18;
   localparam logic [15:0] CAP_ID_VENDOR = 16'h000B;
   localparam logic [15:0] VHDR_ID       = 16'h0008;
   localparam logic [11:0] VHDR_LEN      = 12'h020;

   typedef struct packed {
      logic [11:0] next_ptr;
      logic [3:0]  version;
      logic [15:0] id;
   } cap_word_t;
endpackage

// File: rtl/jsh_id_words.sv
module jsh_id_words
   import jsh_pkg::*;
#(
   parameter logic [11:0] NEXT_PTR = 12'h000,
   parameter logic [3:0]  CAP_VER  = 4'h1,
   parameter logic [3:0]  VHDR_REV = 4'h0
) (
   output logic [REG_W-1:0] cap_word,
   output logic [REG_W-1:0] vhdr_word
);
   cap_word_t cap_s, vh_s;

   always_comb begin
      cap_s.next_ptr = NEXT_PTR;
      cap_s.version  = CAP_VER;
      cap_s.id       = CAP_ID_VENDOR;
      vh_s.next_ptr  = VHDR_LEN;
      vh_s.version   = VHDR_REV;
      vh_s.id        = VHDR_ID;
   end

   assign cap_word  = cap_s;
   assign vhdr_word = vh_s;
endmodule

// File: rtl/jsh_tick.sv
module jsh_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/jsh_shifter.sv
module jsh_shifter #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 6,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  nbits,
   input  logic [DATA_W-1:0] tms_vec,
   input  logic [DATA_W-1:0] tdi_vec,
   input  logic [DIV_W-1:0]  half,
   input  logic              tdo,
   output logic              tck,
   output logic              tms,
   output logic              tdi,
   output logic              busy,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned IDX_W = $clog2(DATA_W);

   logic [DATA_W-1:0] tms_sh, tdi_sh;
   logic [IDX_W-1:0]  idx;
   logic [LEN_W-1:0]  n_q;
   logic              tick;
   logic              last;

   jsh_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .half (half),
      .tick (tick)
   );

   assign last = (LEN_W'(idx) + LEN_W'(1)) == n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tck    <= 1'b0;
         tms    <= 1'b0;
         tdi    <= 1'b0;
         idx    <= '0;
         n_q    <= '0;
         tms_sh <= '0;
         tdi_sh <= '0;
         result <= '0;
      end else if (start) begin
         result <= '0;
         idx    <= '0;
         n_q    <= nbits;
         tck    <= 1'b0;
         if (nbits != '0) begin
            busy   <= 1'b1;
            tms    <= tms_vec[0];
            tdi    <= tdi_vec[0];
            tms_sh <= tms_vec;
            tdi_sh <= tdi_vec;
         end
      end else if (busy && tick) begin
         if (!tck) begin
            tck         <= 1'b1;
            result[idx] <= tdo;
         end else begin
            tck <= 1'b0;
            if (last) begin
               busy <= 1'b0;
            end else begin
               idx    <= idx + IDX_W'(1);
               tms    <= tms_sh[1];
               tdi    <= tdi_sh[1];
               tms_sh <= tms_sh >> 1;
               tdi_sh <= tdi_sh >> 1;
            end
         end
      end
   end

   // R3: no clock edges outside an operation
   a_r3_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tck);
   // R4: data lines hold while TCK is high
   a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));
   // R7: busy ends with the final falling edge
   a_r7_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(tck));
   // R8: zero-length start does not run
   a_r8_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start && nbits == '0) |=> !busy);
endmodule

// File: rtl/jsh_regs.sv
module jsh_regs
   import jsh_pkg::*;
#(
   parameter int unsigned MAX_BITS   = 32,
   parameter int unsigned LEN_W      = 6,
   parameter int unsigned DIV_W      = 8,
   parameter int unsigned FIXED_HALF = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [REG_W-1:0]  cap_word,
   input  logic [REG_W-1:0]  vhdr_word,
   input  logic              busy,
   input  logic [REG_W-1:0]  result,
   output logic              start,
   output logic [LEN_W-1:0]  nbits,
   output logic [REG_W-1:0]  tms_vec,
   output logic [DIV_W-1:0]  half
);
   logic [LEN_W-1:0] len_q;
   logic [DIV_W-1:0] half_raw;
   logic             wr_ok;

   assign wr_ok = reg_wr && !busy;
   assign start = wr_ok && (reg_addr == OFS_DATA);
   assign nbits = (len_q > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         tms_vec <= '0;
      end else if (wr_ok) begin
         if (reg_addr == OFS_LEN) len_q   <= reg_wdata[LEN_W-1:0];
         if (reg_addr == OFS_TMS) tms_vec <= reg_wdata;
      end
   end

   generate
      if (FIXED_HALF != 0) begin : g_fixed_half
         assign half_raw = DIV_W'(FIXED_HALF);
         assign half     = DIV_W'(FIXED_HALF);
      end else begin : g_prog_half
         logic [DIV_W-1:0] half_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            half_q <= DIV_W'(1);
            else if (wr_ok && reg_addr == OFS_HALF) half_q <= reg_wdata[DIV_W-1:0];
         end
         assign half_raw = half_q;
         assign half     = (half_q == '0) ? DIV_W'(1) : half_q;
         // R9: programmed half period frozen during an operation
         a_r9_half_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && $past(busy)) |-> $stable(half_q));
      end
   endgenerate

   always_comb begin
      unique case (reg_addr)
         OFS_CAP:  reg_rdata = cap_word;
         OFS_VHDR: reg_rdata = vhdr_word;
         OFS_STAT: reg_rdata = {{(REG_W-1){1'b0}}, busy};
         OFS_LEN:  reg_rdata = REG_W'(len_q);
         OFS_TMS:  reg_rdata = tms_vec;
         OFS_DATA: reg_rdata = result;
         OFS_HALF: reg_rdata = REG_W'(half_raw);
         default:  reg_rdata = '0;
      endcase
   end

   // R9: length and TMS vector frozen while busy
   a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(len_q) && $stable(tms_vec)));
   // R6: effective half period never zero
   always_comb a_r6_half_nonzero: assert (half != '0);
endmodule

// File: rtl/jsh_engine.sv
module jsh_engine
   import jsh_pkg::*;
#(
   parameter int unsigned   MAX_BITS   = 32,
   parameter int unsigned   DIV_W      = 8,
   parameter int unsigned   FIXED_HALF = 0,
   parameter logic [11:0]   NEXT_PTR   = 12'h000,
   parameter logic [3:0]    CAP_VER    = 4'h1,
   parameter logic [3:0]    VHDR_REV   = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              jtag_tck,
   output logic              jtag_tms,
   output logic              jtag_tdi,
   input  logic              jtag_tdo,
   output logic              busy
);
   localparam int unsigned LEN_W = 6;

   generate
      if (MAX_BITS < 1 || MAX_BITS > REG_W) begin : g_bad_bits
         $error("jsh_engine: MAX_BITS must lie in 1..32");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("jsh_engine: DIV_W must lie in 1..16");
      end
      if (FIXED_HALF >= (1 << DIV_W)) begin : g_bad_fixed
         $error("jsh_engine: FIXED_HALF does not fit DIV_W");
      end
   endgenerate

   logic [REG_W-1:0] cap_word, vhdr_word, tms_vec, result;
   logic [LEN_W-1:0] nbits;
   logic [DIV_W-1:0] half;
   logic             start;

   jsh_id_words #(
      .NEXT_PTR(NEXT_PTR), .CAP_VER(CAP_VER), .VHDR_REV(VHDR_REV)
   ) u_id (
      .cap_word (cap_word),
      .vhdr_word(vhdr_word)
   );

   jsh_regs #(
      .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .DIV_W(DIV_W), .FIXED_HALF(FIXED_HALF)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .cap_word (cap_word),
      .vhdr_word(vhdr_word),
      .busy     (busy),
      .result   (result),
      .start    (start),
      .nbits    (nbits),
      .tms_vec  (tms_vec),
      .half     (half)
   );

   jsh_shifter #(
      .DATA_W(REG_W), .LEN_W(LEN_W), .DIV_W(DIV_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .nbits  (nbits),
      .tms_vec(tms_vec),
      .tdi_vec(reg_wdata),
      .half   (half),
      .tdo    (jtag_tdo),
      .tck    (jtag_tck),
      .tms    (jtag_tms),
      .tdi    (jtag_tdi),
      .busy   (busy),
      .result (result)
   );
endmodule

// File: tb/jsh_engine_tb.sv
module jsh_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tck, tms, tdi, tdo, busy;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int base = 0;
   int exp_half = 1;
   int per_err = 0;
   int last_rise = 0;
   logic [63:0] cap_tms = '0;
   logic [63:0] cap_tdi = '0;
   logic [31:0] tdo_pat = '0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jsh_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jtag_tck(tck),
      .jtag_tms(tms), .jtag_tdi(tdi), .jtag_tdo(tdo), .busy(busy)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // chain model: TDO follows a pattern indexed by rising edges of this op
   assign tdo = ((rise_cnt - base) >= 0 && (rise_cnt - base) < 32) ?
                tdo_pat[rise_cnt - base] : 1'b0;

   always @(posedge tck) begin
      int k;
      k = rise_cnt - base;
      if (k >= 0 && k < 64) begin
         cap_tms[k] <= tms;
         cap_tdi[k] <= tdi;
      end
      if (k > 0 && (cyc - last_rise) != 2 * exp_half) per_err <= per_err + 1;
      last_rise <= cyc;
      rise_cnt  <= rise_cnt + 1;
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] msk(int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
   endfunction

   // program, start, wait, then check everything one operation shows
   task automatic run_op(int len, logic [31:0] tmsv, logic [31:0] tdiv,
                         int half, logic [31:0] pat, string tag);
      int n, eh, bcnt, r0, p0;
      logic [31:0] d;
      n  = (len > 32) ? 32 : len;
      eh = (half == 0) ? 1 : half;
      wr(8'h18, half);
      wr(8'h0C, len);
      wr(8'h10, tmsv);
      exp_half = eh;
      tdo_pat = pat;
      base = rise_cnt;
      r0 = rise_cnt;
      p0 = per_err;
      cap_tms = '0; cap_tdi = '0;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = tdiv;
      @(negedge clk);
      reg_wr = 1'b0;
      bcnt = 0;
      while (busy && bcnt < 5000) begin
         bcnt++;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk({"R3 pulses ", tag}, rise_cnt - r0, n);
      chk({"R3 tck low after ", tag}, tck, 1'b0);
      chk({"R4 tms order ", tag}, cap_tms, {32'h0, tmsv & msk(n)});
      chk({"R4 tdi order ", tag}, cap_tdi, {32'h0, tdiv & msk(n)});
      rd(8'h14, d);
      chk({"R5 result ", tag}, d, pat & msk(n));
      chk({"R7 busy cycles ", tag}, bcnt, 2 * eh * n);
      chk({"R6 half period ", tag}, per_err - p0, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R11 tck", tck, 0);
      chk("R11 tms", tms, 0);
      chk("R11 tdi", tdi, 0);
      chk("R11 busy", busy, 0);
      rd(8'h00, d); chk("R1 capability word", d, 32'h0001000B);
      rd(8'h04, d); chk("R2 vendor header", d, 32'h02000008);
      rd(8'h08, d); chk("R11 status", d, 0);
      rd(8'h0C, d); chk("R11 length", d, 0);
      rd(8'h10, d); chk("R11 tms reg", d, 0);
      rd(8'h14, d); chk("R11 result", d, 0);
      rd(8'h18, d); chk("R6 half reset", d, 1);
   endtask

   task automatic t_zero_len();
      logic [31:0] d;
      int r0, seen;
      run_op(4, 32'hF, 32'h5, 1, 32'hF, "pre");
      r0 = rise_cnt;
      seen = 0;
      wr(8'h0C, 0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (10) begin
         if (busy) seen++;
         @(negedge clk);
      end
      chk("R8 zero len busy", seen, 0);
      chk("R8 zero len pulses", rise_cnt - r0, 0);
      rd(8'h14, d); chk("R8 zero len result", d, 0);
   endtask

   task automatic t_busy_writes();
      logic [31:0] d;
      int r0, bcnt;
      wr(8'h18, 3);
      wr(8'h0C, 8);
      wr(8'h10, 32'h81);
      exp_half = 3;
      tdo_pat = 32'h5A;
      base = rise_cnt;
      r0 = rise_cnt;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h3;
      @(negedge clk);
      reg_wr = 1'b0;
      wr(8'h0C, 5);
      wr(8'h10, 32'hFFFF);
      wr(8'h18, 1);
      wr(8'h14, 32'hFF);
      bcnt = 0;
      while (busy && bcnt < 5000) begin
         bcnt++;
         @(negedge clk);
      end
      repeat (20) @(negedge clk);
      chk("R9 pulses unchanged", rise_cnt - r0, 8);
      chk("R9 no restart", busy, 0);
      rd(8'h0C, d); chk("R9 length kept", d, 8);
      rd(8'h10, d); chk("R9 tms kept", d, 32'h81);
      rd(8'h18, d); chk("R9 half kept", d, 3);
      rd(8'h14, d); chk("R9 result kept", d, 32'h5A);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_op(8, 32'hA5, 32'h3C, 2, 32'h96, "basic");
      run_op(32, 32'hDEAD_BEEF, 32'h1234_5678, 1, 32'hC3A5_0F69, "full");
      run_op(5, 32'h0, 32'h0, 1, 32'h0, "R10 idle clocking");
      run_op(1, 32'h1, 32'h1, 4, 32'h1, "single");
      run_op(3, 32'h6, 32'h5, 0, 32'h7, "half zero");
      run_op(40, 32'h8000_0001, 32'hF0F0_F0F0, 1, 32'hFFFF_FFFF, "R8 clamp");
      run_op(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 32'hABC, "upper zero");
      t_zero_len();
      t_busy_writes();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule